// File: doc/BRIEF.md
# Dual Filament Warm-up Timer

This block decides when the heaters of two klystron tubes have been warm for long enough that high voltage may be switched on. It keeps two countdowns. The first is a retriggerable interval timer. It measures how long a start command has been held high without a break. The start command is high only while every voltage proof and every current proof from both filaments is present. The second is a slower supervisory countdown. It advances on a periodic tick, and only while the filament contactor reports closed.

The supervisory countdown is loaded with a long interval at reset. When the start command appears, any remaining time above a shorter ceiling is cut down to that ceiling. The supervisory path therefore never makes the operator wait much longer than the interval timer itself. The warm-up is declared complete only when both paths have expired. The block drives the start command out to the interval hardware and reports the supervisory result on its own output. All lengths are parameters in clock cycles or tick counts, so short values can be used in simulation.

Top module: `fil_warmup_timer`

## Requirements
- R1: `relay_start` is high exactly when all four proofs (`prf_cur_a`, `prf_cur_b`, `prf_volt_a`, `prf_volt_b`) are high. It is combinational and has no clock delay.
- R2: The interval path expires on the HW_CYCLES-th rising clock edge at which `relay_start` has been continuously high, and stays expired while `relay_start` remains high.
- R3: Any break in `relay_start` discards the elapsed interval. After the command returns, a full HW_CYCLES edges are needed again.
- R4: The interval expiry clears in the same cycle in which `relay_start` goes low, so `warm_done` falls without a clock delay.
- R5: Synchronous reset (`rst` high at a clock edge) loads the supervisory count with SUP_FULL, clears `sup_done` and idles the interval counter. All outputs read low afterwards, provided the proofs are low.
- R6: The supervisory count decrements by one at a clock edge only when `tick_en` is high, `contactor_ok` is high and the count is nonzero. Otherwise it holds, apart from the ceiling rule.
- R7: At every clock edge where `relay_start` is high and the supervisory count exceeds SUP_CLAMP, the count is forced to SUP_CLAMP. This takes priority over decrementing.
- R8: `sup_done` rises at the tick edge on which the count reaches zero with `contactor_ok` high. It then stays high until reset.
- R9: `warm_done` is high exactly when the interval path has expired and `sup_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle supervisory tick strobe |
| prf_cur_a | input | 1 | Filament current proof, tube A |
| prf_cur_b | input | 1 | Filament current proof, tube B |
| prf_volt_a | input | 1 | Filament voltage proof, tube A |
| prf_volt_b | input | 1 | Filament voltage proof, tube B |
| contactor_ok | input | 1 | Filament contactor closed proof |
| relay_start | output | 1 | Start command for the interval timer |
| sup_done | output | 1 | Supervisory countdown complete |
| warm_done | output | 1 | Both warm-up paths complete |

## Verification
A supervisory count that is off by one, whether it started wrong, missed the ceiling or stepped without a tick, appears only as `sup_done` rising one tick early or late. The bench therefore counts ticks exactly, both from the full load and from the ceiling. A wrong interval counter appears as `warm_done` rising one edge early or late after the proofs return. A counter that fails to restart is visible after a mid-interval dropout. An expiry flag that clears late keeps `warm_done` high for a cycle after a proof falls, and this is sampled within the same cycle.

// File: rtl/fwt_pkg.sv
package fwt_pkg;

   // Bits needed to hold values 0..maxval, never less than one.
   function automatic int fwt_bits(input longint maxval);
      int n;
      n = 1;
      while ((longint'(1) << n) <= maxval) n++;
      return n;
   endfunction

   // Action taken by the supervisory counter at a clock edge.
   typedef enum logic [1:0] {
      SUP_ACT_HOLD  = 2'd0,
      SUP_ACT_CLAMP = 2'd1,
      SUP_ACT_STEP  = 2'd2
   } sup_act_e;

endpackage

// File: rtl/fwt_proof_gate.sv
module fwt_proof_gate #(
   parameter int N_PROOFS = 4
) (
   input  logic [N_PROOFS-1:0] proofs,
   output logic                all_ok
);

   if (N_PROOFS < 1) begin : g_bad_n
      $error("fwt_proof_gate: N_PROOFS must be at least 1");
   end

   logic [N_PROOFS:0] chain;
   assign chain[0] = 1'b1;

   for (genvar i = 0; i < N_PROOFS; i++) begin : g_and
      assign chain[i+1] = chain[i] & proofs[i];
   end

   assign all_ok = chain[N_PROOFS];

endmodule

// File: rtl/fwt_hw_window.sv
module fwt_hw_window #(
   parameter int unsigned CYCLES = 880_000
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic expired
);

   localparam int W = fwt_pkg::fwt_bits(longint'(CYCLES));
   localparam logic [W-1:0] LIMIT = W'(CYCLES);

   if (CYCLES < 1) begin : g_bad_len
      $error("fwt_hw_window: CYCLES must be at least 1");
   end

   logic [W-1:0] held_q;
   logic         at_limit;

   assign at_limit = (held_q == LIMIT);

   // Counts edges with start continuously high, saturating at LIMIT.
   always_ff @(posedge clk) begin
      if (rst || !start) begin
         held_q <= '0;
      end else if (!at_limit) begin
         held_q <= held_q + 1'b1;
      end
   end

   assign expired = start & at_limit;

   a_r3_restart_on_drop : assert property (@(posedge clk) disable iff (rst)
      !start |=> (held_q == '0))
      else $error("a_r3_restart_on_drop");

   a_r2_steady_count : assert property (@(posedge clk) disable iff (rst)
      (start && !at_limit) |=> (held_q == $past(held_q) + 1'b1))
      else $error("a_r2_steady_count");

   a_r2_no_overshoot : assert property (@(posedge clk) disable iff (rst)
      held_q <= LIMIT)
      else $error("a_r2_no_overshoot");

endmodule

// File: rtl/fwt_sup_timer.sv
module fwt_sup_timer #(
   parameter int unsigned FULL     = 27300,
   parameter int unsigned CEILING  = 16380,
   parameter bit          CLAMP_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic contactor,
   input  logic start,
   output logic done
);
   import fwt_pkg::*;

   localparam int W = fwt_bits(longint'(FULL));
   localparam logic [W-1:0] LOAD = W'(FULL);
   localparam logic [W-1:0] CEIL = W'(CEILING);

   if (FULL < 1) begin : g_bad_full
      $error("fwt_sup_timer: FULL must be at least 1");
   end
   if (CLAMP_EN && (CEILING >= FULL)) begin : g_bad_ceil
      $error("fwt_sup_timer: CEILING must be below FULL");
   end

   logic [W-1:0] cnt_q;
   logic         done_q;
   logic         clamp_hit;
   logic         step_ok;
   sup_act_e     act;

   if (CLAMP_EN) begin : g_clamp
      assign clamp_hit = start & (cnt_q > CEIL);
   end else begin : g_noclamp
      assign clamp_hit = 1'b0;
   end

   assign step_ok = tick & contactor;

   always_comb begin
      if (clamp_hit) begin
         act = SUP_ACT_CLAMP;
      end else if (step_ok && (cnt_q != '0)) begin
         act = SUP_ACT_STEP;
      end else begin
         act = SUP_ACT_HOLD;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= LOAD;
         done_q <= 1'b0;
      end else begin
         case (act)
            SUP_ACT_CLAMP: cnt_q <= CEIL;
            SUP_ACT_STEP:  cnt_q <= cnt_q - 1'b1;
            default:       cnt_q <= cnt_q;
         endcase
         if (step_ok && (cnt_q <= W'(1)) && !clamp_hit) begin
            done_q <= 1'b1;
         end
      end
   end

   assign done = done_q;

   a_r5_reset_load : assert property (@(posedge clk)
      rst |=> (cnt_q == LOAD && !done_q))
      else $error("a_r5_reset_load");

   a_r6_hold_without_tick : assert property (@(posedge clk) disable iff (rst)
      (!step_ok && !clamp_hit) |=> $stable(cnt_q))
      else $error("a_r6_hold_without_tick");

   a_r7_ceiling : assert property (@(posedge clk) disable iff (rst)
      clamp_hit |=> (cnt_q == CEIL))
      else $error("a_r7_ceiling");

   a_r8_done_sticky : assert property (@(posedge clk) disable iff (rst)
      done_q |=> done_q)
      else $error("a_r8_done_sticky");

   a_r8_done_at_zero : assert property (@(posedge clk) disable iff (rst)
      $rose(done_q) |-> (cnt_q == '0))
      else $error("a_r8_done_at_zero");

endmodule

// File: rtl/fil_warmup_timer.sv
module fil_warmup_timer #(
   parameter int unsigned HW_CYCLES = 880_000,
   parameter int unsigned SUP_FULL  = 27300,
   parameter int unsigned SUP_CLAMP = 16380,
   parameter bit          CLAMP_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_en,
   input  logic prf_cur_a,
   input  logic prf_cur_b,
   input  logic prf_volt_a,
   input  logic prf_volt_b,
   input  logic contactor_ok,
   output logic relay_start,
   output logic sup_done,
   output logic warm_done
);

   localparam int N_PROOFS = 4;

   logic [N_PROOFS-1:0] proofs;
   logic                start_w;
   logic                hw_expired;
   logic                sup_w;

   assign proofs = {prf_volt_b, prf_volt_a, prf_cur_b, prf_cur_a};

   fwt_proof_gate #(.N_PROOFS(N_PROOFS)) u_gate (
      .proofs (proofs),
      .all_ok (start_w)
   );

   fwt_hw_window #(.CYCLES(HW_CYCLES)) u_hw (
      .clk     (clk),
      .rst     (rst),
      .start   (start_w),
      .expired (hw_expired)
   );

   fwt_sup_timer #(
      .FULL     (SUP_FULL),
      .CEILING  (SUP_CLAMP),
      .CLAMP_EN (CLAMP_EN)
   ) u_sup (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick_en),
      .contactor (contactor_ok),
      .start     (start_w),
      .done      (sup_w)
   );

   assign relay_start = start_w;
   assign sup_done    = sup_w;
   assign warm_done   = hw_expired & sup_w;

   a_r1_start_needs_proofs : assert property (@(posedge clk) disable iff (rst)
      relay_start |-> (prf_cur_a && prf_cur_b && prf_volt_a && prf_volt_b))
      else $error("a_r1_start_needs_proofs");

   a_r9_warm_needs_sup : assert property (@(posedge clk) disable iff (rst)
      warm_done |-> (sup_done && relay_start))
      else $error("a_r9_warm_needs_sup");

   a_r4_drop_clears : assert property (@(posedge clk) disable iff (rst)
      !relay_start |-> !warm_done)
      else $error("a_r4_drop_clears");

endmodule

// File: tb/fil_warmup_timer_tb_top.sv
module fil_warmup_timer_tb_top;

   localparam int HW  = 20;
   localparam int FUL = 12;
   localparam int CLP = 7;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick_en = 1'b0;
   logic [3:0] pr = 4'h0;
   logic contactor_ok = 1'b0;
   logic relay_start, sup_done, warm_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   fil_warmup_timer #(
      .HW_CYCLES(HW), .SUP_FULL(FUL), .SUP_CLAMP(CLP), .CLAMP_EN(1'b1)
   ) dut_i (
      .clk(clk), .rst(rst), .tick_en(tick_en),
      .prf_cur_a(pr[0]), .prf_cur_b(pr[1]), .prf_volt_a(pr[2]), .prf_volt_b(pr[3]),
      .contactor_ok(contactor_ok),
      .relay_start(relay_start), .sup_done(sup_done), .warm_done(warm_done)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; pr = 4'h0; tick_en = 1'b0; contactor_ok = 1'b0;
      @(negedge clk); @(negedge clk); rst = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
      #1;
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      #1;
      // R5: outputs idle after reset
      chk(relay_start, 1'b0, "R5 relay_start after reset");
      chk(sup_done, 1'b0, "R5 sup_done after reset");
      chk(warm_done, 1'b0, "R5 warm_done after reset");

      // R1: sweep all proof combinations
      for (int v = 0; v < 16; v++) begin
         pr = 4'(v); #1;
         chk(relay_start, (v == 15), "R1 proof AND");
      end
      do_reset();

      // R6: ticks without contactor do nothing
      for (int i = 0; i < 2*FUL; i++) pulse_tick();
      chk(sup_done, 1'b0, "R6 no step without contactor");
      // R6: contactor closed but no tick: no progress
      contactor_ok = 1'b1;
      edges(3*FUL);
      chk(sup_done, 1'b0, "R6 no step without tick");
      // R8: full count from load
      for (int i = 0; i < FUL-1; i++) pulse_tick();
      chk(sup_done, 1'b0, "R8 one tick before zero");
      pulse_tick();
      chk(sup_done, 1'b1, "R8 done at zero");
      contactor_ok = 1'b0;
      edges(5);
      chk(sup_done, 1'b1, "R8 done sticky");
      chk(warm_done, 1'b0, "R9 no interval yet");

      // R2: interval expiry counted in edges
      @(negedge clk) pr = 4'hF;
      edges(HW-1);
      chk(warm_done, 1'b0, "R2 one edge before expiry");
      edges(1);
      chk(warm_done, 1'b1, "R2 expiry");
      edges(10);
      chk(warm_done, 1'b1, "R2 stays expired");
      // R4: immediate clear on drop
      @(negedge clk) pr = 4'hB; #1;
      chk(warm_done, 1'b0, "R4 same-cycle clear");
      chk(relay_start, 1'b0, "R1 drop of one proof");
      // R3: restart after dropout
      edges(2);
      @(negedge clk) pr = 4'hF;
      edges(HW-1);
      chk(warm_done, 1'b0, "R3 full interval needed");
      edges(1);
      chk(warm_done, 1'b1, "R3 expiry after restart");
      // R3: mid-interval dropout
      @(negedge clk) pr = 4'h7;
      @(negedge clk) pr = 4'hF;
      edges(HW/2);
      @(negedge clk) pr = 4'hE;
      @(negedge clk) pr = 4'hF;
      edges(HW-1);
      chk(warm_done, 1'b0, "R3 mid dropout restarts");
      edges(1);
      chk(warm_done, 1'b1, "R3 expiry after mid dropout");

      // R5: reset clears the done flag
      do_reset(); #1;
      chk(sup_done, 1'b0, "R5 done cleared by reset");
      chk(warm_done, 1'b0, "R5 warm cleared by reset");

      // R7: ceiling when start appears; R9 interval alone is not enough
      @(negedge clk) pr = 4'hF;
      edges(HW + 2);
      chk(warm_done, 1'b0, "R9 interval without supervisory");
      contactor_ok = 1'b1;
      for (int i = 0; i < CLP-1; i++) pulse_tick();
      chk(sup_done, 1'b0, "R7 one tick before ceiling zero");
      pulse_tick();
      chk(sup_done, 1'b1, "R7 done after ceiling count");
      chk(warm_done, 1'b1, "R9 both paths");

      // R7: ceiling applies mid-count; R6 partial count retained
      do_reset();
      contactor_ok = 1'b1;
      for (int i = 0; i < 2; i++) pulse_tick(); // count 10
      @(negedge clk) pr = 4'hF;                 // clamp to 7
      @(negedge clk) pr = 4'h0;
      for (int i = 0; i < CLP-1; i++) pulse_tick();
      chk(sup_done, 1'b0, "R7 mid-count clamp pending");
      pulse_tick();
      chk(sup_done, 1'b1, "R7 mid-count clamp done");

      // R7: count already below ceiling is not raised
      do_reset();
      contactor_ok = 1'b1;
      for (int i = 0; i < FUL-3; i++) pulse_tick(); // count 3
      @(negedge clk) pr = 4'hF;
      edges(2);
      for (int i = 0; i < 2; i++) pulse_tick();
      chk(sup_done, 1'b0, "R7 low count untouched pending");
      pulse_tick();
      chk(sup_done, 1'b1, "R7 low count untouched done");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule